// File: doc/BRIEF.md
# Combined Synchronous/Asynchronous Serial Shifter

This block is one serial engine that covers four jobs with a single shift register and a single bit counter. Its configuration picks one of these jobs: asynchronous transmit, asynchronous receive, synchronous transmit or synchronous receive. In the asynchronous jobs, each word is framed by a low start bit and a high stop bit. A programmable bit period sets the timing, and bits travel least significant first. In the synchronous jobs, an external shift clock drives the bits. That clock comes in on a neighbouring pin, and bits travel most significant first. Each word is either 8 or 32 bits long.

Software or a controlling state machine sets the job with a configuration write. It supplies transmit words through a data input and a load strobe. It collects received words from a held read register, and it acknowledges them with a read strobe. A full-duplex link uses two instances: one set to transmit and one set to receive.

Top module: `serial_shifter_unit`

## Requirements
- R1: After reset, pin_out is high and busy and done are low. pin_out is high whenever busy is low.
- R2: In asynchronous transmit mode (cfg_sync=0, cfg_tx=1), a load sends one frame. The frame is one low start bit, then the data bits least significant first, then one high stop bit, with every bit lasting one bit period. With cfg_wide=0, the frame carries wr_data[7:0]. With cfg_wide=1, it carries all 32 bits.
- R3: A bit-period value n from 1 to 65535 gives bits n clocks long. The value 0 gives bits 65536 clocks long.
- R4: In asynchronous receive mode (cfg_sync=0, cfg_tx=0), a falling pin_in starts a frame. The line is checked again after half a bit period. If it is high by then, the frame is dropped and nothing is received. Otherwise, each data bit is taken at the centre of its period, least significant first. The word appears on rd_data; an 8-bit word is zero-extended.
- R5: In synchronous transmit mode (cfg_sync=1, cfg_tx=1), a load presents the most significant bit on pin_out at once. The output moves to the next bit only on a falling edge of sclk_in. The word is complete after 8 or 32 rising edges. An 8-bit word is taken from wr_data[7:0].
- R6: In synchronous receive mode (cfg_sync=1, cfg_tx=0), pin_in is sampled on each rising edge of sclk_in, most significant bit first. Every 8 or 32 rising edges, one word is placed on rd_data; an 8-bit word is zero-extended.
- R7: done rises when a word has been fully shifted. It falls on rd_ack or wr_load.
- R8: A configuration write aborts any transfer in progress. After it, pin_out is high and busy and done are low.
- R9: rd_data changes only when a received word completes. Transmit activity leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sync | input | 1 | 1 = clocked by sclk_in, 0 = framed with start/stop bits |
| cfg_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_wide | input | 1 | 1 = 32-bit words, 0 = 8-bit words |
| cfg_period | input | 16 | Asynchronous bit period in clocks (0 means 65536) |
| wr_data | input | 32 | Word to transmit |
| wr_load | input | 1 | Starts a transmission of wr_data |
| rd_data | output | 32 | Last received word |
| rd_ack | input | 1 | Read acknowledge; clears done |
| busy | output | 1 | Frame or synchronous transmission in progress |
| done | output | 1 | A word has been fully shifted |
| pin_in | input | 1 | Serial data input |
| sclk_in | input | 1 | Shift clock from the neighbouring pin |
| pin_out | output | 1 | Serial data output |

## Verification
The bench builds the block with its default parameters: 32-bit wide words, 8-bit narrow words and a 16-bit period field. With these values, both word lengths can be exercised in all four jobs. Bit periods of 1, 3, 4, 12 and 16 clocks cover the single-clock case and both even and odd half-period sampling points. Running the full 16-bit period field with the value 0 lets the bench measure a start bit of exactly 65536 clocks, which is the wrap case of the divider. The bench then aborts that frame with a configuration write.

// File: rtl/sershift_pkg.sv
// Shared types for the serial shifter: transfer job and async frame phase.
package sershift_pkg;

    // Transfer job, encoded as {sync, tx}.
    typedef enum logic [1:0] {
        JOB_ASYNC_RX = 2'b00,
        JOB_ASYNC_TX = 2'b01,
        JOB_SYNC_RX  = 2'b10,
        JOB_SYNC_TX  = 2'b11
    } xfer_job_t;

    // Phase of an asynchronous frame.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_START = 2'b01,
        PH_DATA  = 2'b10,
        PH_STOP  = 2'b11
    } frame_ph_t;

endpackage

// File: rtl/pin_edge_sync.sv
// Two-flop synchronizer for W asynchronous inputs.
// Provides the synchronized level and its one-cycle delayed copy so that
// the user can derive rising and falling edges.
// Assumes: inputs may change at any time; RST_VAL gives the idle level.
module pin_edge_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, s3;
        // Metastability chain plus one history stage for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
                s3 <= RST_VAL[i];
            end else begin
                s1 <= raw[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[i]   = s2;
        assign lvl_d[i] = s3;
    end

endmodule

// File: rtl/bit_timer.sv
// Programmable bit-period timer.
// Emits one tick every `period` clocks while running, with 0 meaning
// 2**PERIOD_W. A start may request a first interval of half a period.
// Assumes: start and stop are never asserted together.
module bit_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                half,
    input  logic                stop,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);

    localparam int CW = PERIOD_W + 1;

    logic [CW-1:0] cnt, eff, half_v;
    logic          run;

    // Effective period and its half (never below one clock).
    always_comb begin
        eff    = (period == '0) ? (CW'(1) << PERIOD_W) : {1'b0, period};
        half_v = eff >> 1;
        if (half_v == '0) half_v = CW'(1);
    end

    assign tick = run && (cnt == CW'(1));

    // Down-counter that reloads on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= CW'(1);
        end else if (stop) begin
            run <= 1'b0;
            cnt <= CW'(1);
        end else if (start) begin
            run <= 1'b1;
            cnt <= half ? half_v : eff;
        end else if (tick) begin
            cnt <= eff;
        end else if (run) begin
            cnt <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/shift_core.sv
// Shared shift register and bit counter for all four transfer jobs.
// Shifts right (LSB-first jobs) or left (MSB-first jobs), and flags the
// last bit of an 8- or 32-bit word. Also exposes the next register value.
// Assumes: at most one of ld, sh_r and sh_l is set in a cycle.
module shift_core #(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              ld,
    input  logic [WORD_W-1:0] ld_val,
    input  logic              sh_r,
    input  logic              sh_l,
    input  logic              in_bit,
    input  logic              cnt_clr,
    input  logic              cnt_inc,
    output logic [WORD_W-1:0] sreg,
    output logic [WORD_W-1:0] sreg_nxt,
    output logic              cnt_last
);

    localparam int CNT_W = $clog2(WORD_W);

    logic [CNT_W-1:0] cnt;

    // Next shift-register value for the requested operation.
    always_comb begin
        if (ld)        sreg_nxt = ld_val;
        else if (sh_r) sreg_nxt = {in_bit, sreg[WORD_W-1:1]};
        else if (sh_l) sreg_nxt = {sreg[WORD_W-2:0], in_bit};
        else           sreg_nxt = sreg;
    end

    assign cnt_last = (cnt == (wide ? CNT_W'(WORD_W - 1) : CNT_W'(NARROW_W - 1)));

    // Shift-register and bit-counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else begin
            sreg <= sreg_nxt;
            if (cnt_clr)      cnt <= '0;
            else if (cnt_inc) cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/serial_shifter_unit.sv
// Combined serial shifter: async TX/RX with start/stop framing and a
// programmable bit period, or sync TX/RX clocked by an external shift clock.
// Async jobs are LSB-first, sync jobs MSB-first; words are 8 or 32 bits.
// Assumes: sclk_in is much slower than clk (at least ~4 clocks per phase);
// the configuration is written while the link is quiet.
module serial_shifter_unit
    import sershift_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 8,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_sync,
    input  logic                cfg_tx,
    input  logic                cfg_wide,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                wr_load,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                rd_ack,
    output logic                busy,
    output logic                done,
    input  logic                pin_in,
    input  logic                sclk_in,
    output logic                pin_out
);

    localparam int PAD_W = WORD_W - NARROW_W;
    localparam logic [WORD_W-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};

    // ---------------- configuration ----------------
    logic                m_sync, m_tx, m_wide;
    logic [PERIOD_W-1:0] m_period;
    xfer_job_t           job;

    // Configuration register; resets to async transmit, 8 bits, period 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_sync   <= 1'b0;
            m_tx     <= 1'b1;
            m_wide   <= 1'b0;
            m_period <= PERIOD_W'(1);
        end else if (cfg_we) begin
            m_sync   <= cfg_sync;
            m_tx     <= cfg_tx;
            m_wide   <= cfg_wide;
            m_period <= cfg_period;
        end
    end

    assign job = xfer_job_t'({m_sync, m_tx});

    // ---------------- input synchronizers ----------------
    logic [1:0] lvl, lvl_d;
    logic       din_lvl, din_fall, sclk_rise, sclk_fall;

    pin_edge_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sclk_in, pin_in}),
        .lvl   (lvl),
        .lvl_d (lvl_d)
    );

    assign din_lvl   = lvl[0];
    assign din_fall  = !lvl[0] && lvl_d[0];
    assign sclk_rise = lvl[1] && !lvl_d[1];
    assign sclk_fall = !lvl[1] && lvl_d[1];

    // ---------------- datapath instances ----------------
    logic              t_start, t_half, t_stop, tick;
    logic              sh_ld, sh_r, sh_l, in_bit, cnt_clr, cnt_inc, cnt_last;
    logic [WORD_W-1:0] ld_val, sreg, sreg_nxt;

    bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (t_start),
        .half   (t_half),
        .stop   (t_stop),
        .period (m_period),
        .tick   (tick)
    );

    shift_core #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (m_wide),
        .ld       (sh_ld),
        .ld_val   (ld_val),
        .sh_r     (sh_r),
        .sh_l     (sh_l),
        .in_bit   (in_bit),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .sreg     (sreg),
        .sreg_nxt (sreg_nxt),
        .cnt_last (cnt_last)
    );

    // ---------------- control ----------------
    frame_ph_t ph, ph_nxt;
    logic      stx_busy, stx_busy_nxt;
    logic      fin, cap;

    // Sequencing of all four jobs over the shared timer and shifter.
    always_comb begin
        ph_nxt       = ph;
        stx_busy_nxt = stx_busy;
        t_start      = 1'b0;
        t_half       = 1'b0;
        t_stop       = 1'b0;
        sh_ld        = 1'b0;
        ld_val       = wr_data;
        sh_r         = 1'b0;
        sh_l         = 1'b0;
        in_bit       = din_lvl;
        cnt_clr      = 1'b0;
        cnt_inc      = 1'b0;
        fin          = 1'b0;
        cap          = 1'b0;
        if (cfg_we) begin
            ph_nxt       = PH_IDLE;
            stx_busy_nxt = 1'b0;
            t_stop       = 1'b1;
            cnt_clr      = 1'b1;
        end else begin
            case (job)
                JOB_ASYNC_TX: begin
                    case (ph)
                        PH_IDLE: if (wr_load) begin
                            sh_ld   = 1'b1;
                            cnt_clr = 1'b1;
                            t_start = 1'b1;
                            ph_nxt  = PH_START;
                        end
                        PH_START: if (tick) ph_nxt = PH_DATA;
                        PH_DATA: if (tick) begin
                            sh_r = 1'b1;
                            if (cnt_last) begin
                                cnt_clr = 1'b1;
                                ph_nxt  = PH_STOP;
                            end else begin
                                cnt_inc = 1'b1;
                            end
                        end
                        PH_STOP: if (tick) begin
                            t_stop = 1'b1;
                            fin    = 1'b1;
                            ph_nxt = PH_IDLE;
                        end
                        default: ph_nxt = PH_IDLE;
                    endcase
                end
                JOB_ASYNC_RX: begin
                    case (ph)
                        PH_IDLE: if (din_fall) begin
                            t_start = 1'b1;
                            t_half  = 1'b1;
                            cnt_clr = 1'b1;
                            ph_nxt  = PH_START;
                        end
                        PH_START: if (tick) begin
                            if (!din_lvl) begin
                                t_start = 1'b1;
                                ph_nxt  = PH_DATA;
                            end else begin
                                t_stop = 1'b1;
                                ph_nxt = PH_IDLE;
                            end
                        end
                        PH_DATA: if (tick) begin
                            sh_r = 1'b1;
                            if (cnt_last) begin
                                fin     = 1'b1;
                                cap     = 1'b1;
                                cnt_clr = 1'b1;
                                t_stop  = 1'b1;
                                ph_nxt  = PH_IDLE;
                            end else begin
                                cnt_inc = 1'b1;
                            end
                        end
                        default: ph_nxt = PH_IDLE;
                    endcase
                end
                JOB_SYNC_TX: begin
                    if (!stx_busy) begin
                        if (wr_load) begin
                            sh_ld        = 1'b1;
                            ld_val       = m_wide ? wr_data : (wr_data << PAD_W);
                            cnt_clr      = 1'b1;
                            stx_busy_nxt = 1'b1;
                        end
                    end else begin
                        in_bit = 1'b0;
                        if (sclk_rise) begin
                            if (cnt_last) begin
                                fin          = 1'b1;
                                cnt_clr      = 1'b1;
                                stx_busy_nxt = 1'b0;
                            end else begin
                                cnt_inc = 1'b1;
                            end
                        end
                        if (sclk_fall) sh_l = 1'b1;
                    end
                end
                default: begin
                    if (sclk_rise) begin
                        sh_l = 1'b1;
                        if (cnt_last) begin
                            fin     = 1'b1;
                            cap     = 1'b1;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Control state and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            stx_busy <= 1'b0;
            done     <= 1'b0;
        end else begin
            ph       <= ph_nxt;
            stx_busy <= stx_busy_nxt;
            if (fin)                               done <= 1'b1;
            else if (rd_ack || wr_load || cfg_we)  done <= 1'b0;
        end
    end

    // Received-word alignment: async words arrive at the top, sync at the bottom.
    logic [WORD_W-1:0] rx_word;
    always_comb begin
        if (m_sync) rx_word = m_wide ? sreg_nxt : (sreg_nxt & NARROW_MASK);
        else        rx_word = m_wide ? sreg_nxt : (sreg_nxt >> PAD_W);
    end

    // Read register, loaded only when a received word completes.
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_data <= '0;
        else if (cap) rd_data <= rx_word;
    end

    // Line driver: start low, data from the shifter, idle and stop high.
    always_comb begin
        pin_out = 1'b1;
        if (job == JOB_ASYNC_TX) begin
            if (ph == PH_START)     pin_out = 1'b0;
            else if (ph == PH_DATA) pin_out = sreg[0];
        end else if (job == JOB_SYNC_TX && stx_busy) begin
            pin_out = sreg[WORD_W-1];
        end
    end

    assign busy = (ph != PH_IDLE) || stx_busy;

endmodule

// File: rtl/serial_shifter_unit_chk.sv
// Property checker for serial_shifter_unit, attached by bind.
// Relates the port-level flags to the internal completion, capture and
// clock-edge signals that separate logic produces.
module serial_shifter_unit_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              pin_out,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_ack,
    input logic              wr_load,
    input logic              cfg_we,
    input logic              fin,
    input logic              cap,
    input logic              sclk_fall,
    input logic              stx_busy
);

    // R1: the line rests high whenever no transfer is running.
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> pin_out);

    // R7: a completed word raises done on the next cycle.
    assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done);

    // R7: a read or a write with no completion drops done.
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ack || wr_load) && !fin) |=> !done);

    // R8: a configuration write leaves the engine idle and the flag clear.
    assert_cfg_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!busy && !done && pin_out));

    // R9: the read register moves only on a capture.
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(rd_data));

    // R5: during a clocked transmission the output holds between falling edges.
    assert_sync_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_busy && !sclk_fall && !fin && !cfg_we) |=> $stable(pin_out));

endmodule

bind serial_shifter_unit serial_shifter_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .pin_out   (pin_out),
    .rd_data   (rd_data),
    .rd_ack    (rd_ack),
    .wr_load   (wr_load),
    .cfg_we    (cfg_we),
    .fin       (fin),
    .cap       (cap),
    .sclk_fall (sclk_fall),
    .stx_busy  (stx_busy)
);

// File: tb/serial_shifter_unit_tb_top.sv
// Scoreboard bench: driver tasks push expected words, monitor tasks pop
// and compare them with what the block puts on the line or on rd_data.
module serial_shifter_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sync = 1'b0, cfg_tx = 1'b0, cfg_wide = 1'b0;
    logic [15:0] cfg_period = 16'd1;
    logic [31:0] wr_data = '0;
    logic        wr_load = 1'b0;
    logic [31:0] rd_data;
    logic        rd_ack = 1'b0;
    logic        busy, done;
    logic        pin_in = 1'b1;
    logic        sclk_in = 1'b0;
    logic        pin_out;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_rx = '0;

    always #4 clk = ~clk;   // 125 MHz

    serial_shifter_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sync(cfg_sync),
        .cfg_tx(cfg_tx), .cfg_wide(cfg_wide), .cfg_period(cfg_period),
        .wr_data(wr_data), .wr_load(wr_load), .rd_data(rd_data),
        .rd_ack(rd_ack), .busy(busy), .done(done), .pin_in(pin_in),
        .sclk_in(sclk_in), .pin_out(pin_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic configure(input bit s, input bit t, input bit w, input int p);
        cfg_sync = s; cfg_tx = t; cfg_wide = w; cfg_period = 16'(p);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_raw(input logic [31:0] word);
        wr_data = word; wr_load = 1'b1;
        @(negedge clk);
        wr_load = 1'b0;
    endtask

    task automatic push_load(input logic [31:0] word, input int n);
        exp_q.push_back(n == 8 ? (word & 32'hFF) : word);
        load_raw(word);
    endtask

    task automatic pop_exp(output logic [31:0] e);
        if (exp_q.size() == 0) e = 'x;
        else e = exp_q.pop_front();
    endtask

    task automatic ack_and_check(input string req);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check(done == 1'b0, req, {31'd0, done}, 32'd0);
    endtask

    // Decodes one async frame from pin_out and compares with the scoreboard.
    task automatic tx_monitor(input int n, input int p, input bit ack);
        logic [31:0] w = '0;
        logic [31:0] e;
        int k = 0;
        while (pin_out !== 1'b0 && k < 1000) begin @(negedge clk); k++; end
        repeat (p / 2) @(negedge clk);
        check(pin_out == 1'b0, "R2 start bit", {31'd0, pin_out}, 32'd0);
        for (int i = 0; i < n; i++) begin
            repeat (p) @(negedge clk);
            w[i] = pin_out;
        end
        repeat (p) @(negedge clk);
        check(pin_out == 1'b1, "R2 stop bit", {31'd0, pin_out}, 32'd1);
        pop_exp(e);
        check(w === e, "R2/R3 frame data", w, e);
        repeat (p + 4) @(negedge clk);
        check(done && !busy, "R7 done after frame", {30'd0, done, busy}, 32'd2);
        if (ack) ack_and_check("R7 rd_ack clears done");
    endtask

    task automatic send_async(input logic [31:0] word, input int n, input int p);
        exp_q.push_back(n == 8 ? (word & 32'hFF) : word);
        pin_in = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            pin_in = word[i];
            repeat (p) @(negedge clk);
        end
        pin_in = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    task automatic send_sync(input logic [31:0] word, input int n);
        exp_q.push_back(n == 8 ? (word & 32'hFF) : word);
        for (int i = n - 1; i >= 0; i--) begin
            pin_in = word[i];
            repeat (2) @(negedge clk);
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
            sclk_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // Waits for a received word and compares rd_data with the scoreboard.
    task automatic rx_monitor(input string req);
        logic [31:0] e;
        int k = 0;
        while (!done && k < 400) begin @(negedge clk); k++; end
        pop_exp(e);
        check(done && rd_data === e, req, rd_data, e);
        last_rx = e;
        ack_and_check("R7 rd_ack clears done");
    endtask

    // Drives sclk for one clocked transmission and checks bits MSB-first.
    task automatic sync_tx_check(input logic [31:0] word, input int n);
        logic [31:0] w = '0;
        logic [31:0] e;
        push_load(word, n);
        repeat (3) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            w[i] = pin_out;
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
        end
        pop_exp(e);
        check(w === e, "R5 clocked transmit data", w, e);
        check(done && !busy, "R5 word complete", {30'd0, done, busy}, 32'd2);
        ack_and_check("R7 rd_ack clears done");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out && !busy && !done, "R1 reset state",
              {29'd0, pin_out, busy, done}, 32'd4);

        // Async transmit, 8 bits, period 4; done left pending.
        configure(0, 1, 0, 4);
        push_load(32'h0000_00A5, 8);
        tx_monitor(8, 4, 0);
        // A new load clears the pending done.
        push_load(32'hDEAD_BE3C, 8);
        check(done == 1'b0, "R7 wr_load clears done", {31'd0, done}, 32'd0);
        tx_monitor(8, 4, 1);

        // Async transmit, 32 bits, odd period.
        configure(0, 1, 1, 3);
        push_load(32'h1234_ABCD, 32);
        tx_monitor(32, 3, 1);

        // Single-clock bits.
        configure(0, 1, 0, 1);
        push_load(32'h0000_005A, 8);
        tx_monitor(8, 1, 1);

        // Period 0: start bit lasts 65536 clocks, then abort by reconfiguring.
        configure(0, 1, 0, 0);
        load_raw(32'h0000_0001);
        begin
            int w = 0;
            while (pin_out == 1'b0 && w < 70000) begin @(negedge clk); w++; end
            check(w == 65536, "R3 period zero start width", 32'(w), 32'd65536);
        end
        repeat (10) @(negedge clk);
        configure(0, 1, 0, 4);
        check(pin_out && !busy && !done, "R8 config aborts",
              {29'd0, pin_out, busy, done}, 32'd4);

        // Async receive.
        configure(0, 0, 0, 16);
        send_async(32'h3C, 8, 16);
        rx_monitor("R4 async receive 3C");
        send_async(32'h81, 8, 16);
        rx_monitor("R4 async receive 81");
        // False start: short low glitch must be dropped.
        pin_in = 1'b0;
        repeat (3) @(negedge clk);
        pin_in = 1'b1;
        repeat (40) @(negedge clk);
        check(!done && !busy, "R4 false start ignored", {30'd0, done, busy}, 32'd0);
        send_async(32'hC3, 8, 16);
        rx_monitor("R4 async receive after glitch");
        configure(0, 0, 1, 12);
        send_async(32'hCAFE_F00D, 32, 12);
        rx_monitor("R4 async receive 32-bit");

        // Clocked receive.
        configure(1, 0, 0, 1);
        send_sync(32'h0000_0096, 8);
        rx_monitor("R6 clocked receive 8-bit");
        configure(1, 0, 1, 1);
        send_sync(32'h8765_4321, 32);
        rx_monitor("R6 clocked receive 32-bit");

        // Clocked transmit; rd_data must keep the last received word.
        configure(1, 1, 0, 1);
        sync_tx_check(32'h1234_56B2, 8);
        configure(1, 1, 1, 1);
        sync_tx_check(32'hF0E1_D2C3, 32);
        check(rd_data === last_rx, "R9 rd_data held over transmit", rd_data, last_rx);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule